// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block is the timing and control core of a small processor. It splits every machine cycle into four clocks, Q1 to Q4, and runs two stages at once: while the instruction held in the instruction register is being executed, the next instruction is read from program memory. It owns the program counter and the instruction register. It drives a synchronous program-memory read port. It also issues one strobe per phase to the datapath: decode, operand read, execute and write-back.

The program counter addresses program memory only; data memory and opcode meaning belong to the datapath. After reset the first machine cycle only fetches, so no strobes appear. A branch request from the datapath is taken at the end of Q4. It reloads the program counter and discards the instruction that was fetched alongside, so the next machine cycle executes nothing.

Top module: `fetch_exec_sequencer`

## Requirements
- R1: While reset is low and in the first clock after it, the phase output is 4'b0001 (Q1), the program counter equals RESET_VEC, the instruction register is zero, ir_valid is 0, pmem_rd is 0 and no strobe is high.
- R2: The phase output is always one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It advances one position per clock and wraps from Q4 to Q1.
- R3: At the end of Q1 the program counter increments by one, wrapping modulo 2^ADDR_W. In Q2 and Q3 it holds its value.
- R4: pmem_rd is high in Q2 only. During Q2, pmem_addr equals the program counter value that was present during Q1 of the same machine cycle. The memory returns the word on the following clock.
- R5: The instruction register loads pmem_data at the end of Q4 and holds its value at every other edge.
- R6: decode_en is high in Q1, operand_rd in Q2, exec_en in Q3 and wb_en in Q4, each for exactly that one clock. Each strobe is high only while ir_valid is 1.
- R7: The first machine cycle after reset issues no strobes. ir_valid becomes 1 at the end of its Q4, so the word at RESET_VEC executes in the second machine cycle.
- R8: If branch is high at the end of Q4 while ir_valid is 1, the program counter loads branch_target and ir_valid becomes 0 for the next machine cycle. That cycle issues no strobes.
- R9: branch has no effect in Q1, Q2 or Q3, or while ir_valid is 0. The program counter and ir_valid then behave as if branch were low.
- R10: While instruction N executes, the word fetched in the same machine cycle is the one that executes next. After a flushed cycle, the first instruction executed is the word at branch_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pmem_addr | output | ADDR_W | Program memory read address |
| pmem_rd | output | 1 | Program memory read enable (Q2) |
| pmem_data | input | INSTR_W | Word returned one clock after the read |
| branch | input | 1 | Branch request from datapath |
| branch_target | input | ADDR_W | New program counter on a taken branch |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |
| pc | output | ADDR_W | Program counter |
| ir | output | INSTR_W | Instruction register |
| ir_valid | output | 1 | Instruction register holds an instruction to execute |
| decode_en | output | 1 | Q1 strobe |
| operand_rd | output | 1 | Q2 strobe |
| exec_en | output | 1 | Q3 strobe |
| wb_en | output | 1 | Q4 strobe |

## Verification
A wrong phase register shows at the ports within one clock: either phase loses its one-hot form, or a strobe or pmem_rd appears in the wrong slot. A wrong program counter or fetch address shows as a bad pmem_addr at the next Q2. It then shows as a wrong ir at the end of that machine cycle, which is at most four clocks later. A wrong valid flag shows at the next phase, when a strobe appears during a flushed or first cycle, or goes missing after a normal one. A reference model compares every one of these outputs on every clock. Its stimulus includes branches in every phase, branches during flushed cycles, and targets that wrap the counter.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int NUM_PHASES = 4;
  localparam int PH_Q1 = 0;
  localparam int PH_Q2 = 1;
  localparam int PH_Q3 = 2;
  localparam int PH_Q4 = 3;

  localparam logic [NUM_PHASES-1:0] PHASE_RESET = 4'b0001;

  // next phase of the ring: each bit moves up one, Q4 wraps to Q1
  function automatic logic [NUM_PHASES-1:0] phase_advance(input logic [NUM_PHASES-1:0] cur);
    return {cur[NUM_PHASES-2:0], cur[NUM_PHASES-1]};
  endfunction

endpackage

// File: rtl/fes_phase_gen.sv
module fes_phase_gen
  import fes_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [NUM_PHASES-1:0] phase
);

  logic [NUM_PHASES-1:0] phase_q;
  logic [NUM_PHASES-1:0] phase_nxt;

  assign phase_nxt = phase_advance(phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PHASE_RESET;
    else        phase_q <= phase_nxt;
  end

  assign phase = phase_q;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_q) == 1);                                  // R2
  AST_PHASE_ORDER_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q[PH_Q1] |=> phase_q[PH_Q2]);                         // R2
  AST_PHASE_ORDER_Q4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q[PH_Q4] |=> phase_q[PH_Q1]);                         // R2

endmodule

// File: rtl/fes_fetch_unit.sv
module fes_fetch_unit
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int INSTR_W   = 14,
  parameter int RESET_VEC = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase,
  input  logic                  branch,
  input  logic [ADDR_W-1:0]     branch_target,
  input  logic [INSTR_W-1:0]    pmem_data,
  output logic [ADDR_W-1:0]     pmem_addr,
  output logic                  pmem_rd,
  output logic [ADDR_W-1:0]     pc,
  output logic [INSTR_W-1:0]    ir,
  output logic                  ir_valid
);

  localparam logic [ADDR_W-1:0] PC_RESET = ADDR_W'(RESET_VEC);

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0]  pc_q;
  logic [ADDR_W-1:0]  fetch_addr_q;
  logic [INSTR_W-1:0] ir_q;
  logic               ir_valid_q;

  // named internal events
  logic in_q1, in_q2, in_q4;
  logic take_branch;
  logic ir_load;

  assign in_q1       = phase[PH_Q1];
  assign in_q2       = phase[PH_Q2];
  assign in_q4       = phase[PH_Q4];
  assign take_branch = in_q4 & branch & ir_valid_q;
  assign ir_load     = in_q4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q         <= PC_RESET;
      fetch_addr_q <= PC_RESET;
      ir_q         <= '0;
      ir_valid_q   <= 1'b0;
    end else begin
      if (in_q1) begin
        fetch_addr_q <= pc_q;
        pc_q         <= pc_step(pc_q);
      end
      if (ir_load) begin
        ir_q <= pmem_data;
        if (take_branch) begin
          pc_q       <= branch_target;
          ir_valid_q <= 1'b0;
        end else begin
          ir_valid_q <= 1'b1;
        end
      end
    end
  end

  assign pmem_addr = fetch_addr_q;
  assign pmem_rd   = in_q2;
  assign pc        = pc_q;
  assign ir        = ir_q;
  assign ir_valid  = ir_valid_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_q1 |=> pc_q == $past(pc_q) + ADDR_W'(1));                 // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PH_Q2] | phase[PH_Q3]) |=> $stable(pc_q));            // R3
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    in_q1 |=> pmem_addr == $past(pc_q));                         // R4
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_q4 |=> $stable(ir_q));                                   // R5
  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch |=> (!ir_valid_q && pc_q == $past(branch_target))); // R8
  AST_NO_BRANCH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q4 && !take_branch) |=> ir_valid_q);                     // R9
  AST_VALID_ONLY_Q4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_q4 |=> $stable(ir_valid_q));                             // R7

endmodule

// File: rtl/fes_strobe_gen.sv
module fes_strobe_gen
  import fes_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase,
  input  logic                  ir_valid,
  output logic [NUM_PHASES-1:0] strobe
);

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_strobe
    assign strobe[g] = phase[g] & ir_valid;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));                                           // R6
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |-> ir_valid);                                // R6
  AST_STROBE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |-> (strobe == phase));                       // R6

endmodule

// File: rtl/fetch_exec_sequencer.sv
module fetch_exec_sequencer
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int INSTR_W   = 14,
  parameter int RESET_VEC = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [ADDR_W-1:0]  pmem_addr,
  output logic               pmem_rd,
  input  logic [INSTR_W-1:0] pmem_data,
  input  logic               branch,
  input  logic [ADDR_W-1:0]  branch_target,
  output logic [3:0]         phase,
  output logic [ADDR_W-1:0]  pc,
  output logic [INSTR_W-1:0] ir,
  output logic               ir_valid,
  output logic               decode_en,
  output logic               operand_rd,
  output logic               exec_en,
  output logic               wb_en
);

  logic [NUM_PHASES-1:0] phase_w;
  logic [NUM_PHASES-1:0] strobe_w;
  logic                  ir_valid_w;

  fes_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase_w)
  );

  fes_fetch_unit #(
    .ADDR_W    (ADDR_W),
    .INSTR_W   (INSTR_W),
    .RESET_VEC (RESET_VEC)
  ) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase         (phase_w),
    .branch        (branch),
    .branch_target (branch_target),
    .pmem_data     (pmem_data),
    .pmem_addr     (pmem_addr),
    .pmem_rd       (pmem_rd),
    .pc            (pc),
    .ir            (ir),
    .ir_valid      (ir_valid_w)
  );

  fes_strobe_gen u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_w),
    .ir_valid (ir_valid_w),
    .strobe   (strobe_w)
  );

  assign phase      = phase_w;
  assign ir_valid   = ir_valid_w;
  assign decode_en  = strobe_w[PH_Q1];
  assign operand_rd = strobe_w[PH_Q2];
  assign exec_en    = strobe_w[PH_Q3];
  assign wb_en      = strobe_w[PH_Q4];

  AST_RD_IN_Q2: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_rd |-> phase_w[PH_Q2]);                                 // R4
  AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ir_valid_w && phase_w[PH_Q1]));           // R7

endmodule

// File: tb/fetch_exec_sequencer_bench.sv
module fetch_exec_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int IW = 14;
  localparam int RV = 0;
  localparam int AMASK = (1 << AW) - 1;
  localparam int IMASK = (1 << IW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] pmem_addr;
  logic pmem_rd;
  logic [IW-1:0] pmem_data = '0;
  logic branch = 1'b0;
  logic [AW-1:0] branch_target = '0;
  logic [3:0] phase;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic ir_valid, decode_en, operand_rd, exec_en, wb_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_exec_sequencer #(.ADDR_W(AW), .INSTR_W(IW), .RESET_VEC(RV)) u_fetch_exec_sequencer (
    .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_rd(pmem_rd),
    .pmem_data(pmem_data), .branch(branch), .branch_target(branch_target),
    .phase(phase), .pc(pc), .ir(ir), .ir_valid(ir_valid),
    .decode_en(decode_en), .operand_rd(operand_rd), .exec_en(exec_en), .wb_en(wb_en)
  );

  // program memory contents are a formula of the address
  function automatic int word_at(input int a);
    return ((a * 37) ^ (a << 5) ^ 12'h5a3) & IMASK;
  endfunction

  // synchronous program memory: word appears the clock after a read
  always @(posedge clk) if (pmem_rd) pmem_data <= IW'(word_at(int'(pmem_addr)));

  // reference model state
  int m_clk;          // clocks since reset release; phase = m_clk % 4
  int m_pc;
  int m_next_addr;    // address whose word lands in the IR at the coming Q4
  int m_ir;
  bit m_valid;
  int m_exec_addr;    // address of the instruction now held in the IR

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (clock %0d)", req, what, act, exp, m_clk);
    end
  endtask

  task automatic compare_all();
    int q;
    q = m_clk % 4;
    check("R2", "phase", int'(phase), 1 << q);
    check("R3/R8/R9", "pc", int'(pc), m_pc);
    check("R4", "pmem_rd", int'(pmem_rd), int'(q == 1));
    if (q == 1) check("R4", "pmem_addr", int'(pmem_addr), m_next_addr);
    check("R5/R10", "ir", int'(ir), m_ir);
    check("R7/R8", "ir_valid", int'(ir_valid), int'(m_valid));
    check("R6", "decode_en", int'(decode_en), int'(m_valid && q == 0));
    check("R6", "operand_rd", int'(operand_rd), int'(m_valid && q == 1));
    check("R6", "exec_en", int'(exec_en), int'(m_valid && q == 2));
    check("R6", "wb_en", int'(wb_en), int'(m_valid && q == 3));
    // R10: the executing word is the one stored at the address tracked for it
    if (m_valid) check("R10", "executing word", int'(ir), word_at(m_exec_addr));
  endtask

  // advance the model across one rising edge with the inputs held then
  task automatic model_edge(input bit br, input int tgt);
    case (m_clk % 4)
      0: begin m_next_addr = m_pc; m_pc = (m_pc + 1) & AMASK; end
      3: begin
        m_ir = word_at(m_next_addr);
        m_exec_addr = m_next_addr;
        if (br && m_valid) begin m_pc = tgt; m_valid = 0; end   // R8
        else m_valid = 1;                                        // R9
      end
      default: ;
    endcase
    m_clk++;
  endtask

  int lfsr = 32'h1d87;
  function automatic int next_rand(input int s);
    return (s * 1103515245 + 12345) & 32'h7fffffff;
  endfunction

  task automatic run_clock(input bit br, input int tgt);
    branch = br;
    branch_target = AW'(tgt);
    @(negedge clk);
    model_edge(br, tgt);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset
    check("R1", "phase in reset", int'(phase), 1);
    check("R1", "pc in reset", int'(pc), RV);
    check("R1", "ir_valid in reset", int'(ir_valid), 0);
    check("R1", "ir in reset", int'(ir), 0);
    check("R1", "strobes in reset", int'({decode_en, operand_rd, exec_en, wb_en, pmem_rd}), 0);
    rst_n = 1'b1;
    m_clk = 0; m_pc = RV; m_next_addr = RV; m_ir = 0; m_valid = 0; m_exec_addr = RV;
    compare_all();
    // R7: first machine cycle is fetch only, no strobes
    for (int i = 0; i < 4; i++) begin
      run_clock(1'b1, 8'h40);   // R9: branch while ir_valid is 0 is ignored
      if (i < 3) check("R7", "no strobe in first cycle",
                       int'({decode_en, operand_rd, exec_en, wb_en}), 0);
    end
    // plain sequential execution, long enough to wrap the counter (R3)
    for (int i = 0; i < 1100; i++) run_clock(1'b0, 0);
    // R9: branch raised only in Q1..Q3 has no effect
    for (int i = 0; i < 200; i++) run_clock((m_clk % 4) != 3, 8'h77);
    // R8/R10: random branches in any phase, random targets including wrap edge
    for (int i = 0; i < 1600; i++) begin
      int t;
      lfsr = next_rand(lfsr);
      t = ((lfsr >> 8) % 5 == 0) ? AMASK : ((lfsr >> 12) & AMASK);
      run_clock(((lfsr >> 4) % 3) == 0, t);
    end
    // R8: branch held high, alternating taken and flushed cycles
    for (int i = 0; i < 120; i++) run_clock(1'b1, AMASK - 1);
    for (int i = 0; i < 40; i++) run_clock(1'b0, 0);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule